// File: doc/BRIEF.md
# Write-Only I2C Target with Fixed Address

This block is the receive side of a two-wire serial link that feeds a display controller. It watches the clock and data lines of an I2C bus. It cleans both lines with a synchroniser and a majority filter, and it recognises the START and STOP conditions. After a START it collects the 7-bit address and the direction bit. It answers only the one hard-wired address, and only when the direction is write.

Once the address is accepted, every later byte is acknowledged. After each acknowledge clock the byte is handed to a downstream command or data handler as a one-cycle strobe. The block never sends data. The only time it touches SDA is to pull it low for an acknowledge, through an open-drain enable. Clock stretching and read transfers are not offered.

Top module: `i2c_wr_target`

## Requirements
- R1: While `rst_n` is low and after it is released, `sda_oe` and `rx_valid` are 0 and `rx_data` is 0, and the block waits for a START.
- R2: A START is SDA going from 1 to 0 while SCL is 1. It begins reception of an address byte at bit 0 of the byte. Bits are taken on SCL rising edges, most significant first, eight per byte, and a ninth clock follows for the acknowledge.
- R3: An address byte of 8'h7C (address 7'b0111110 followed by direction bit 0, meaning write) is acknowledged. `sda_oe` is 1 from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock, and it is 0 at every other time.
- R4: An address byte with any other address, or with the direction bit at 1, gets no acknowledge. Every later byte is then ignored, with no acknowledge and no `rx_valid`, until the next START or STOP.
- R5: Each data byte after an accepted address is acknowledged as in R3. At the SCL falling edge that ends its ninth clock, `rx_valid` pulses for exactly one clk cycle with the byte on `rx_data`, bit 7 being the first bit received.
- R6: A START in the middle of a byte or after an acknowledge drops the partial byte. The next byte is then treated as an address byte.
- R7: A STOP is SDA going from 0 to 1 while SCL is 1. It returns the block to idle from any state. Clock pulses after a STOP and before the next START produce no acknowledge and no `rx_valid`.
- R8: A pulse of a single clk cycle on SCL or on SDA has no effect on the outputs, because of the 3-tap majority filter.
- R9: If SCL rises and SDA falls in the same clk cycle, the block treats it as a START and does not take a data bit.
- R10: A line change present before clk rising edge k shows up in `sda_oe`, `rx_valid` and `rx_data` right after clk rising edge k+4. This is two synchroniser stages plus the filter. The clk must run at least 8 times faster than SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Last received data byte |

## Verification
Two events can fall in the same clk cycle after filtering. One is a SCL rising edge that would shift in a data bit. The other is a SDA falling edge that, with SCL high, forms a START. The bench provokes this by changing both master lines at the same clock edge right after an acknowledged data byte, and then sends a fresh address and byte. The result is judged on two points: the next byte must be acknowledged as an address, and only the bytes sent on each side of the overlap may appear on `rx_data`. A reference model, clocked every cycle, also checks that the acknowledge window and the strobe land on the expected cycles.

// File: rtl/i2c_wr_target.sv
module i2c_wr_target #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data
);

  localparam logic [6:0] OWN_ADDR = 7'b0111110;
  localparam logic [7:0] ADDR_WR  = {OWN_ADDR, 1'b0};
  localparam int         HALF     = FILT_TAPS / 2;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_ACK, S_SKIP} st_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic [FILT_TAPS-1:0]   scl_h, sda_h;
  logic                   scl_f, sda_f, scl_fp, sda_fp;
  logic                   start_det, stop_det, scl_rise, scl_fall;
  st_t                    st;
  logic [3:0]             cnt;
  logic [7:0]             sh;
  logic                   in_addr, ack_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_h  <= '1;
      sda_h  <= '1;
      scl_fp <= 1'b1;
      sda_fp <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_h  <= {scl_h[FILT_TAPS-2:0], scl_sy[SYNC_STAGES-1]};
      sda_h  <= {sda_h[FILT_TAPS-2:0], sda_sy[SYNC_STAGES-1]};
      scl_fp <= scl_f;
      sda_fp <= sda_f;
    end
  end

  assign scl_f     = int'($countones(scl_h)) > HALF;
  assign sda_f     = int'($countones(sda_h)) > HALF;
  assign start_det = scl_f & sda_fp & ~sda_f;
  assign stop_det  = scl_f & ~sda_fp & sda_f;
  assign scl_rise  = scl_f & ~scl_fp;
  assign scl_fall  = ~scl_f & scl_fp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      in_addr  <= 1'b0;
      ack_data <= 1'b0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st      <= S_RECV;
        in_addr <= 1'b1;
        cnt     <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          S_RECV: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (!in_addr) begin
                sda_oe   <= 1'b1;
                ack_data <= 1'b1;
                st       <= S_ACK;
              end else if (sh == ADDR_WR) begin
                sda_oe   <= 1'b1;
                ack_data <= 1'b0;
                in_addr  <= 1'b0;
                st       <= S_ACK;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              cnt      <= '0;
              st       <= S_RECV;
              rx_valid <= ack_data;
              if (ack_data) rx_data <= sh;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic scl_fp,
  input logic start_det,
  input logic stop_det,
  input logic skipping,
  input logic sda_oe,
  input logic rx_valid
);

  assert_oe_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (($past(scl_fp) && !$past(scl_f)) || $past(start_det) || $past(stop_det)));

  assert_skip_is_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> (!sda_oe && !rx_valid));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_strobe_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(scl_fp) && !$past(scl_f)));

  assert_start_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !rx_valid));

  assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !rx_valid));

endmodule

bind i2c_wr_target i2c_wr_target_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .scl_fp    (scl_fp),
  .start_det (start_det),
  .stop_det  (stop_det),
  .skipping  (st == S_SKIP),
  .sda_oe    (sda_oe),
  .rx_valid  (rx_valid)
);

// File: tb/i2c_wr_target_tb.sv
module i2c_wr_target_tb_top;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_line;
  logic       sda_oe, rx_valid;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_wr_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int compared = 0;
  int mismatched = 0;
  logic [7:0] got_q[$];
  logic [7:0] want_q[$];

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // reference model: line history, majority view, behavioural protocol
  bit rscl[$], rsda[$];
  bit pf_scl, pf_sda, f_scl, f_sda;
  int m_st, m_cnt;
  bit [7:0] m_sh;
  bit m_addr, m_ackd, e_oe, e_val;
  bit [7:0] e_dat;

  function automatic bit maj3(bit a, bit b, bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rscl = {1, 1, 1, 1, 1, 1};
      rsda = {1, 1, 1, 1, 1, 1};
      pf_scl = 1; pf_sda = 1; m_st = 0; m_cnt = 0; m_sh = 0;
      m_addr = 0; m_ackd = 0; e_oe = 0; e_val = 0; e_dat = 0;
    end else begin
      rscl.push_front(m_scl); void'(rscl.pop_back());
      rsda.push_front(sda_line); void'(rsda.pop_back());
      f_scl = maj3(rscl[3], rscl[4], rscl[5]);
      f_sda = maj3(rsda[3], rsda[4], rsda[5]);
      e_val = 0;
      if (f_scl && !pf_sda && f_sda) begin
        m_st = 0; e_oe = 0;
      end else if (f_scl && pf_sda && !f_sda) begin
        m_st = 1; m_addr = 1; m_cnt = 0; e_oe = 0;
      end else if (m_st == 1) begin
        if (f_scl && !pf_scl && m_cnt < 8) begin
          m_sh = {m_sh[6:0], f_sda}; m_cnt++;
        end else if (!f_scl && pf_scl && m_cnt == 8) begin
          if (!m_addr) begin e_oe = 1; m_ackd = 1; m_st = 2; end
          else if (m_sh == 8'h7C) begin e_oe = 1; m_ackd = 0; m_addr = 0; m_st = 2; end
          else m_st = 3;
        end
      end else if (m_st == 2 && !f_scl && pf_scl) begin
        e_oe = 0; m_cnt = 0; m_st = 1; e_val = m_ackd;
        if (m_ackd) e_dat = m_sh;
      end
      pf_scl = f_scl; pf_sda = f_sda;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 ack window sda_oe", sda_oe, e_oe);
      chk("R5 strobe rx_valid", rx_valid, e_val);
      if (e_val) chk("R5 byte rx_data", rx_data, e_dat);
      if (rx_valid) got_q.push_back(rx_data);
    end
  end

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
  endtask

  task automatic do_stop();
    m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(2 * Q);
  endtask

  task automatic send_bit(bit b);
    m_sda = b; w(Q); m_scl = 1; w(2 * Q); m_scl = 0; w(Q);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(1'b1);
  endtask

  task automatic glitch_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(3); m_scl = 1; w(1); m_scl = 0; w(Q - 4);
      m_scl = 1; w(Q - 2); m_sda = ~b[i]; w(1); m_sda = b[i]; w(Q + 1);
      m_scl = 0; w(Q);
    end
    send_bit(1'b1);
  endtask

  task automatic judge(string tag);
    chk({tag, " byte count"}, got_q.size(), want_q.size());
    for (int i = 0; i < want_q.size() && i < got_q.size(); i++)
      chk({tag, " byte value"}, got_q[i], want_q[i]);
    got_q.delete();
    want_q.delete();
  endtask

  initial begin
    w(2);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R1 reset rx_data", rx_data, 0);
    w(3);
    rst_n = 1;
    w(20);
    chk("R1 idle after reset", {sda_oe, rx_valid}, 0);

    // R2 R3 R5 basic write
    do_start(); send_byte(8'h7C); send_byte(8'hA5); send_byte(8'h3C); do_stop();
    want_q = {8'hA5, 8'h3C}; judge("R2/R5 basic write");

    // R4 wrong address, then read direction
    do_start(); send_byte(8'h7E); send_byte(8'h55); do_stop();
    judge("R4 wrong address");
    do_start(); send_byte(8'h7D); send_byte(8'h55); do_stop();
    judge("R4 read direction");
    do_start(); send_byte(8'h20); send_byte(8'h11);
    do_start(); send_byte(8'h7C); send_byte(8'h66); do_stop();
    want_q = {8'h66}; judge("R4 skip until start");

    // R6 repeated start mid-byte
    do_start(); send_byte(8'h7C); send_bit(1); send_bit(0); send_bit(1);
    do_start(); send_byte(8'h7C); send_byte(8'h81); do_stop();
    want_q = {8'h81}; judge("R6 restart mid-byte");

    // R7 stop returns idle
    do_start(); send_byte(8'h7C); send_byte(8'h12); do_stop();
    send_byte(8'h99); send_byte(8'h7C);
    want_q = {8'h12}; judge("R7 bytes after stop");
    do_start(); send_byte(8'h7C); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    do_stop(); send_byte(8'h44);
    judge("R7 stop mid-byte");

    // R8 single-cycle glitches
    do_start(); send_byte(8'h7C); glitch_byte(8'hC3); do_stop();
    want_q = {8'hC3}; judge("R8 glitch filtered");

    // R9 SCL rise and SDA fall together
    do_start(); send_byte(8'h7C); send_byte(8'h0F);
    m_sda = 1; w(Q); m_scl = 1; m_sda = 0; w(Q); m_scl = 0; w(Q);
    send_byte(8'h7C); send_byte(8'hF0); do_stop();
    want_q = {8'h0F, 8'hF0}; judge("R9 coincident edges");

    w(40);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

endmodule